// File: doc/BRIEF.md
# Windowed Threshold Exceedance Detector

This block watches a stream of unsigned samples, one per valid strobe, and reports whether any of the most recent `WIN_LEN` samples was strictly greater than a threshold input. It keeps no copy of the samples. Each sample is compared on arrival. A saturating gap counter records how many non-exceeding samples have arrived since the last exceedance. The flag is true while that gap is shorter than the window. The result is exact and needs no memory and no modulo address arithmetic.

The threshold is expected to stay constant during operation. When software or a neighbouring block changes it, pulsing the clear input restarts the window, so decisions made against the old threshold are dropped. A second counter reports when a whole window of samples has been seen since reset or clear. Downstream logic can use it to ignore the flag while the window is still filling.

Top module: `wtd_detector`

## Requirements
- R1: After reset the flag `hit_o` is 0 and `full_o` is 0.
- R2: A valid sample with `data_i > thr_i` sets `hit_o` to 1 on the clock edge that takes the sample.
- R3: A sample equal to the threshold is not an exceedance. It does not set `hit_o`.
- R4: `hit_o` is 1 exactly when at least one of the last `WIN_LEN` valid samples exceeded the threshold. It falls on the edge that takes the `WIN_LEN`-th non-exceeding sample after the last exceedance.
- R5: In a cycle with `valid_i` low and `clr_i` low, `hit_o` and `full_o` keep their values.
- R6: `full_o` rises on the edge that takes the `WIN_LEN`-th valid sample since reset or clear. It then stays 1 until the next reset or clear.
- R7: `clr_i` high at a clock edge drives `hit_o` and `full_o` to 0. It takes priority over a valid sample in the same cycle, and that sample is discarded.
- R8: The gap counter saturates at `WIN_LEN` and never wraps. Any run of non-exceeding samples, however long, leaves `hit_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| data_i | input | DATA_W | Unsigned sample |
| thr_i | input | DATA_W | Unsigned threshold |
| clr_i | input | 1 | Synchronous window restart |
| hit_o | output | 1 | An exceedance lies within the last WIN_LEN samples |
| full_o | output | 1 | WIN_LEN samples seen since reset or clear |

## Verification
The bench uses a small configuration (8-sample window, 4-bit data). It sweeps every threshold value and drives every data value against each one, plus pseudo-random streams with idle gaps. Its reference is an OR over a shift register of the last comparison results. Directed runs place an exceedance at each window edge: a design whose window is off by one drops the flag one sample early or late. Equal-to-threshold samples expose a comparison that is not strict. Long quiet runs expose a counter that wraps and raises the flag again. Clear issued together with a valid sample exposes a design where the sample beats the clear, and the flag or fill count would survive it.

// File: rtl/wtd_pkg.sv
package wtd_pkg;
  function automatic int cnt_width(input int win);
    return $clog2(win + 1);
  endfunction
endpackage

// File: rtl/wtd_cmp.sv
module wtd_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              above_o
);
  // strict compare, unsigned
  assign above_o = data_i > thr_i;
endmodule

// File: rtl/wtd_gap_cnt.sv
module wtd_gap_cnt #(
  parameter int WIN_LEN = 100,
  localparam int CNT_W = wtd_pkg::cnt_width(WIN_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic above_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] gap_q;

  // gap_q: non-exceeding samples since last exceedance, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= SAT;
    else if (clr_i)       gap_q <= SAT;
    else if (valid_i) begin
      if (above_i)        gap_q <= '0;
      else if (gap_q != SAT) gap_q <= gap_q + 1'b1;
    end
  end

  assign hit_o = gap_q < SAT;

  AST_GAP_ZERO_ON_EXCEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && above_i && !clr_i |=> gap_q == '0); // R2
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q == SAT && !clr_i && !(valid_i && above_i) |=> gap_q == SAT); // R8
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> gap_q <= SAT); // R8
endmodule

// File: rtl/wtd_fill_cnt.sv
module wtd_fill_cnt #(
  parameter int WIN_LEN = 100,
  localparam int CNT_W = wtd_pkg::cnt_width(WIN_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  output logic full_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fill_q <= '0;
    else if (clr_i)                 fill_q <= '0;
    else if (valid_i && fill_q != SAT) fill_q <= fill_q + 1'b1;
  end

  assign full_o = fill_q == SAT;

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clr_i |=> full_o); // R6
endmodule

// File: rtl/wtd_detector.sv
module wtd_detector #(
  parameter int DATA_W  = 16,
  parameter int WIN_LEN = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              clr_i,
  output logic              hit_o,
  output logic              full_o
);
  logic above;

  wtd_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data_i (data_i),
    .thr_i  (thr_i),
    .above_o(above)
  );

  wtd_gap_cnt #(.WIN_LEN(WIN_LEN)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .valid_i(valid_i),
    .above_i(above),
    .hit_o  (hit_o)
  );

  wtd_fill_cnt #(.WIN_LEN(WIN_LEN)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .valid_i(valid_i),
    .full_o (full_o)
  );

  AST_HIT_ON_EXCEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_i && data_i > thr_i |=> hit_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !clr_i |=> $stable(hit_o) && $stable(full_o)); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_o && !full_o); // R7
  AST_FALL_ON_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hit_o) |-> $past(clr_i) || ($past(valid_i) && $past(data_i) <= $past(thr_i))); // R4
endmodule

// File: tb/tb_wtd_detector.sv
`timescale 1ns/1ps
module tb_wtd_detector;
  localparam int DW  = 4;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic clr_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] thr_i = '0;
  logic hit_o, full_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WIN-1:0] hist = '0;
  int filled = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  wtd_detector #(.DATA_W(DW), .WIN_LEN(WIN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .thr_i(thr_i), .clr_i(clr_i), .hit_o(hit_o), .full_o(full_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (thr=%0d t=%0t)", tag, act, exp, thr_i, $time);
    end
  endtask

  // drive one cycle, update model, check after the edge
  task automatic step(input logic v, input logic [DW-1:0] d, input logic c,
                      input string tag_hit, input string tag_full);
    @(negedge clk);
    valid_i = v; data_i = d; clr_i = c;
    if (c) begin
      hist = '0; filled = 0;
    end else if (v) begin
      hist = {hist[WIN-2:0], d > thr_i};
      if (filled < WIN) filled++;
    end
    @(posedge clk);
    #2;
    check(tag_hit, hit_o, |hist);
    check(tag_full, full_o, filled == WIN);
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 hit after reset", hit_o, 1'b0);
    check("R1 full after reset", full_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int t = 0; t < (1 << DW); t++) begin
      @(negedge clk);
      thr_i = DW'(t);
      step(1'b0, '0, 1'b1, "R7 clear hit", "R7 clear full");
      // equal sample is no exceedance
      step(1'b1, DW'(t), 1'b0, "R3 equal sample", "R6 fill");
      // every data value against this threshold
      for (int d = 0; d < (1 << DW); d++)
        step(1'b1, DW'(d), 1'b0, "R2 sweep", "R6 fill");
      if (t < (1 << DW) - 1) begin
        // exceedance then quiet run across the window edge
        step(1'b1, DW'(t + 1), 1'b0, "R2 exceed", "R6 fill");
        for (int k = 1; k < WIN; k++)
          step(1'b1, DW'(t), 1'b0, "R4 inside window", "R6 fill");
        step(1'b1, '0, 1'b0, "R4 window edge fall", "R6 fill");
        for (int k = 0; k < 3 * WIN; k++)
          step(1'b1, '0, 1'b0, "R8 long quiet", "R6 fill");
        // idle hold with flag set
        step(1'b1, DW'(t + 1), 1'b0, "R2 exceed", "R6 fill");
        for (int k = 0; k < 3; k++)
          step(1'b0, DW'(t + 1), 1'b0, "R5 idle hit", "R5 idle full");
        // clear with exceeding sample in same cycle
        step(1'b1, DW'(t + 1), 1'b1, "R7 clear beats sample", "R7 clear full");
      end
      // pseudo-random stream with gaps
      for (int k = 0; k < 40; k++) begin
        next_lfsr();
        step(lfsr[5:4] != 2'b00, lfsr[3:0], 1'b0, "R4 random", "R6 random");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule